// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block chooses, once per cell slot, which inputs of an N x N input-queued switch may send to which outputs. Each input holds one virtual output queue per output. The input to the block is a request matrix with one bit per queue, set when that queue is non-empty. The output is a matching: each input is paired with at most one output, and each output with at most one input.

A slot begins with a one-cycle `start` pulse that captures the request matrix. The block then runs a fixed number of request-grant-accept rounds, one per clock. In each round, every output that is still free picks one requesting free input, scanning round-robin from its own grant pointer. Every free input that receives grants then takes one of them, scanning round-robin from its own accept pointer. Pairs accepted in a round are added to the matching. Only the pairs accepted in the first round move the pointers. An output pointer moves only when its grant is accepted. This keeps the output arbiters from staying aligned on the same input.

After the last round, `done` pulses for one cycle. The matching then stays on `match` until the next slot starts.

Top module: `rr_voq_matcher`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `done` is 0 and `match` is all zeros. All grant and accept pointers reset to index 0.
- R2: At `done`, every row of `match` and every column of `match` has at most one bit set. Bit `i*N+j` pairs input i with output j, for both `req` and `match`.
- R3: A `match` bit is set only if the same bit of `req` was set when the slot was started.
- R4: A free output with several eligible requests grants the first input found when scanning upward, with wraparound, from its grant pointer.
- R5: After a first-round accept, the output's grant pointer becomes (granted input + 1) mod N. An output whose grant is not accepted keeps its pointer.
- R6: A free input that receives several grants accepts the first output found when scanning upward, with wraparound, from its accept pointer. That pointer then becomes (accepted output + 1) mod N.
- R7: An input or an output that was matched in an earlier round of the same slot takes no part in later rounds of that slot.
- R8: Pointers change only for pairs accepted in the first round of a slot. Pairs added in later rounds leave the pointers as they are.
- R9: `done` is high for exactly one cycle. It is seen ITERS cycles after the clock edge that accepted `start`. `match` holds its value from then until the next accepted `start`.
- R10: A `start` pulse that arrives while a slot is still running is ignored. It does not change the timing or the result of the running slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a slot and captures `req` |
| req | input | N*N | Queue-occupancy matrix; bit i*N+j is set when input i has cells for output j |
| done | output | 1 | One-cycle pulse when the matching of the slot is final |
| match | output | N*N | Matching; bit i*N+j is set when input i is connected to output j |

## Verification
A fully set request matrix is run twice from reset. The first slot shows the second round filling in behind the first (R7), with only one pointer pair moving. The second slot gives a different result only if the grant pointers held still when their grants were lost (R5), and only if the second-round pairs were kept out of the pointer update (R8).

A single request and an empty matrix check that the block invents no pairs (R3). A second `start` sent during a running slot must leave that slot's timing and result unchanged (R10). Random matrices of mixed density then compare the block, slot after slot, against a reference model of the requirements. Pointer state carries across slots, so any error in a rotation rule shows up in a later matching.

// File: rtl/rr_match_pkg.sv
package rr_match_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Index one place beyond idx, wrapping at n.
    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 4,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  sel,
    output logic [PW-1:0] idx
);
    logic found;

    // Scan from ptr upward with wraparound; first set bit wins.
    always_comb begin
        sel   = '0;
        idx   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(ptr) + k;
            if (pos >= N) pos = pos - N;
            if (!found && req[pos]) begin
                found    = 1'b1;
                sel[pos] = 1'b1;
                idx      = PW'(pos);
            end
        end
    end
endmodule

// File: rtl/rr_match_iter.sv
module rr_match_iter #(
    parameter int N  = 4,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0][N-1:0]  req_m,
    input  logic [N-1:0][N-1:0]  match_m,
    input  logic [N-1:0][PW-1:0] gptr,
    input  logic [N-1:0][PW-1:0] aptr,
    output logic [N-1:0][N-1:0]  acc_m,
    output logic [N-1:0][PW-1:0] g_idx,
    output logic [N-1:0][PW-1:0] a_idx,
    output logic [N-1:0]         g_won,
    output logic [N-1:0]         a_won
);
    logic [N-1:0]         in_busy;
    logic [N-1:0]         out_busy;
    logic [N-1:0][N-1:0]  col_req;   // [output][input]
    logic [N-1:0][N-1:0]  gnt;       // [output][input]
    logic [N-1:0][N-1:0]  gnt_in;    // [input][output]

    always_comb begin
        out_busy = '0;
        for (int i = 0; i < N; i++) begin
            in_busy[i] = |match_m[i];
            for (int j = 0; j < N; j++) begin
                out_busy[j] = out_busy[j] | match_m[i][j];
            end
        end
    end

    // Only free inputs toward free outputs take part in this round.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col_req[j][i] = req_m[i][j] & ~in_busy[i] & ~out_busy[j];
            end
        end
    end

    generate
        for (genvar j = 0; j < N; j++) begin : g_grant
            rr_pick #(.N(N), .PW(PW)) u_grant (
                .req (col_req[j]),
                .ptr (gptr[j]),
                .sel (gnt[j]),
                .idx (g_idx[j])
            );
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                gnt_in[i][j] = gnt[j][i];
            end
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_accept
            rr_pick #(.N(N), .PW(PW)) u_accept (
                .req (gnt_in[i]),
                .ptr (aptr[i]),
                .sel (acc_m[i]),
                .idx (a_idx[i])
            );
        end
    endgenerate

    always_comb begin
        g_won = '0;
        for (int i = 0; i < N; i++) begin
            a_won[i] = |acc_m[i];
            for (int j = 0; j < N; j++) begin
                g_won[j] = g_won[j] | acc_m[i][j];
            end
        end
    end
endmodule

// File: rtl/rr_voq_matcher.sv
module rr_voq_matcher
    import rr_match_pkg::*;
#(
    parameter int N     = 4,
    parameter int ITERS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N*N-1:0]   req,
    output logic             done,
    output logic [N*N-1:0]   match
);
    localparam int PW = $clog2(N);
    localparam int CW = $clog2(ITERS + 1);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    phase_e               phase_q;
    logic [CW-1:0]        iter_q;
    logic [N-1:0][N-1:0]  req_q;
    logic [N-1:0][N-1:0]  match_q;
    logic [N-1:0][PW-1:0] gptr_q;
    logic [N-1:0][PW-1:0] aptr_q;
    logic                 done_q;

    logic [N-1:0][N-1:0]  acc_m;
    logic [N-1:0][PW-1:0] g_idx;
    logic [N-1:0][PW-1:0] a_idx;
    logic [N-1:0]         g_won;
    logic [N-1:0]         a_won;

    rr_match_iter #(.N(N), .PW(PW)) u_iter (
        .req_m   (req_q),
        .match_m (match_q),
        .gptr    (gptr_q),
        .aptr    (aptr_q),
        .acc_m   (acc_m),
        .g_idx   (g_idx),
        .a_idx   (a_idx),
        .g_won   (g_won),
        .a_won   (a_won)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            iter_q  <= '0;
            req_q   <= '0;
            match_q <= '0;
            gptr_q  <= '0;
            aptr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        req_q   <= req;
                        match_q <= '0;
                        iter_q  <= '0;
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    match_q <= match_q | acc_m;
                    iter_q  <= iter_q + 1'b1;
                    if (iter_q == LAST) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                    // Rotate pointers only on the first round's accepts.
                    if (iter_q == '0) begin
                        for (int j = 0; j < N; j++) begin
                            if (g_won[j]) gptr_q[j] <= PW'(wrap_next(int'(g_idx[j]), N));
                        end
                        for (int i = 0; i < N; i++) begin
                            if (a_won[i]) aptr_q[i] <= PW'(wrap_next(int'(a_idx[i]), N));
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done  = done_q;
    assign match = match_q;
endmodule

// File: rtl/rr_voq_matcher_chk.sv
module rr_voq_matcher_chk #(
    parameter int N     = 4,
    parameter int ITERS = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N*N-1:0] req,
    input logic           done,
    input logic [N*N-1:0] match
);
    logic           busy_c;
    int unsigned    cnt_c;
    logic [N*N-1:0] req_c;
    logic [N-1:0][N-1:0] col_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c <= 1'b0;
            cnt_c  <= 0;
            req_c  <= '0;
        end else if (start && (!busy_c || done)) begin
            busy_c <= 1'b1;
            cnt_c  <= 0;
            req_c  <= req;
        end else if (done) begin
            busy_c <= 1'b0;
        end else if (busy_c) begin
            cnt_c <= cnt_c + 1;
        end
    end

    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col_c[j][i] = match[i*N + j];
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!done && match == '0));

    // R9 R10
    done_time_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_c && cnt_c == ITERS));

    // R9
    done_due_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_c && cnt_c == ITERS) |-> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((!busy_c || done) && !start) |=> $stable(match));

    // R3
    subset_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((match & ~req_c) == '0));

    generate
        for (genvar k = 0; k < N; k++) begin : g_line
            // R2
            row_one_chk: assert property (@(posedge clk) disable iff (rst)
                done |-> $onehot0(match[k*N +: N]));
            // R2
            col_one_chk: assert property (@(posedge clk) disable iff (rst)
                done |-> $onehot0(col_c[k]));
        end
    endgenerate
endmodule

bind rr_voq_matcher rr_voq_matcher_chk #(.N(N), .ITERS(ITERS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .req   (req),
    .done  (done),
    .match (match)
);

// File: tb/rr_voq_matcher_test.sv
module rr_voq_matcher_test;
    localparam int N     = 4;
    localparam int ITERS = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [N*N-1:0] req;
    logic           done;
    logic [N*N-1:0] match;

    always #5 clk = ~clk;

    rr_voq_matcher #(.N(N), .ITERS(ITERS)) uut (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .req   (req),
        .done  (done),
        .match (match)
    );

    int checks = 0;
    int errors = 0;
    logic [N*N-1:0] exp_q[$];
    string          tag_q[$];
    int gp[N];
    int ap[N];

    task automatic check(input bit ok, input string tag, input logic [N*N-1:0] act,
                         input logic [N*N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model built from R4..R8.
    task automatic model_slot(input logic [N*N-1:0] r, output logic [N*N-1:0] m);
        bit im[N];
        bit om[N];
        bit gv[N];
        int g[N];
        bit av[N];
        int a[N];
        m = '0;
        for (int x = 0; x < N; x++) begin im[x] = 0; om[x] = 0; end
        for (int it = 0; it < ITERS; it++) begin
            for (int j = 0; j < N; j++) begin
                gv[j] = 0; g[j] = 0;
                if (!om[j]) begin
                    for (int k = 0; k < N; k++) begin
                        int i;
                        i = (gp[j] + k) % N;
                        if (!gv[j] && r[i*N + j] && !im[i]) begin gv[j] = 1; g[j] = i; end
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                av[i] = 0; a[i] = 0;
                if (!im[i]) begin
                    for (int k = 0; k < N; k++) begin
                        int j;
                        j = (ap[i] + k) % N;
                        if (!av[i] && gv[j] && g[j] == i) begin av[i] = 1; a[i] = j; end
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (av[i]) begin
                    m[i*N + a[i]] = 1'b1;
                    im[i] = 1; om[a[i]] = 1;
                    if (it == 0) begin
                        gp[a[i]] = (i + 1) % N;
                        ap[i]    = (a[i] + 1) % N;
                    end
                end
            end
        end
    endtask

    // Driver: pushes the expected matching, then runs one slot.
    task automatic run_slot(input logic [N*N-1:0] r, input logic [N*N-1:0] hand,
                            input bit use_hand, input bit second_start, input string tag);
        logic [N*N-1:0] mexp;
        logic [N*N-1:0] exp;
        int lat;
        model_slot(r, mexp);
        exp = use_hand ? hand : mexp;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req   = r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        if (second_start) begin
            // R10: a start during the running slot must be ignored.
            start = 1'b1;
            req   = ~r;
            @(negedge clk);
            start = 1'b0;
            lat   = 1;
        end
        req = '0;
        while (!done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == ITERS, {"R9 done latency ", tag}, N*N'(lat), N*N'(ITERS));
        @(negedge clk);
        check(done == 1'b0, {"R9 done single cycle ", tag}, N*N'(done), '0);
        check(match == exp, {"R9 match held ", tag}, match, exp);
    endtask

    // Monitor: compares each finished matching against the scoreboard.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", match, '0);
            end else begin
                logic [N*N-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(match == e, t, match, e);
            end
        end
    end

    task automatic main_seq();
        rst = 1'b1; start = 1'b0; req = '0;
        for (int x = 0; x < N; x++) begin gp[x] = 0; ap[x] = 0; end
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", N*N'(done), '0);
        check(match == '0, "R1 match in reset", match, '0);
        rst = 1'b0;
        @(negedge clk);
        check(match == '0, "R1 match after reset", match, '0);

        // All pointers at 0: pair (0,0) in round 1, (1,1) in round 2.
        run_slot('1, 16'h0021, 1'b1, 1'b0, "R4 R7 full matrix first slot");
        // Only out0/in0 moved: (0,1),(1,0) then (2,2).
        run_slot('1, 16'h0412, 1'b1, 1'b0, "R5 R6 R8 full matrix second slot");
        run_slot(16'h0800, 16'h0800, 1'b1, 1'b0, "R3 single request");
        run_slot(16'h0000, 16'h0000, 1'b1, 1'b0, "R3 empty matrix");
        run_slot(16'h8421, 16'h0000, 1'b0, 1'b1, "R10 restart ignored");
        for (int n = 0; n < 40; n++) begin
            logic [N*N-1:0] r;
            r = N*N'($urandom);
            if (n % 3 == 1) r = r & N*N'($urandom);
            if (n % 3 == 2) r = r | N*N'($urandom);
            run_slot(r, '0, 1'b0, 1'b0, "R2 R4 R6 random slot");
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9 all slots completed", N*N'(exp_q.size()), '0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R9 watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule